// File: doc/BRIEF.md
# Translation unit control and fault register block

This block sits beside an address translation pipeline and gives software a small 32-bit register window onto it. Software turns translation on or off, requests that the pipeline stop taking new work, and learns through a status bit when all work already accepted has finished. The block also holds the page table base as a page frame number, and starts a full TLB flush whenever that base is written.

Fault events arrive from the pipeline as one-cycle pulses, one pulse line per fault kind and per direction (read or write), each with the virtual address involved. The block records them as sticky status bits, keeps one faulting address per direction, and raises an interrupt from the unmasked bits. Software clears bits by writing ones. Any fault also forces the unit into the stopped state, and it stays there until software writes the run code again.

The central state machine has four states. ST_OFF: translation disabled. ST_RUN: translating. ST_DRAIN: stop requested, with accepted translations still in flight. ST_HELD: stopped and drained. The transitions: run code from any state goes to ST_RUN. Off code from any state goes to ST_OFF. Stop code or a fault moves ST_OFF or ST_RUN to ST_DRAIN. ST_DRAIN moves to ST_HELD once the in-flight count reaches zero. Any other control value leaves the state unchanged.

Top module: `mmuc_top`

## Requirements
- R1: After reset the unit is in ST_OFF. The control, status, fault-status, fault-address and page-base registers read 0, the interrupt is low, and the interrupt mask at 0x068 reads 0x001F001F.
- R2: A write to 0x000 with 0x5 selects ST_RUN, with 0x0 selects ST_OFF, and with 0x7 selects ST_DRAIN (from ST_OFF or ST_RUN). Any other value is ignored. Reading 0x000 returns 0x0 in ST_OFF, 0x5 in ST_RUN, and 0x7 in ST_DRAIN or ST_HELD. xl_on is high outside ST_OFF, and xl_hold is high in ST_DRAIN and ST_HELD.
- R3: Bit 0 of the status register at 0x008 reads 1 only in ST_HELD. ST_HELD is entered from ST_DRAIN in the same edge at which the in-flight count (xl_start adds one, xl_done subtracts one) becomes zero.
- R4: A read-side pulse on rd_fault[k] sets bit k of the fault status at 0x060, and a write-side pulse on wr_fault[k] sets bit 16+k. The order of k is: 0 walk error, 1 page fault, 2 multi-hit, 3 access protection, 4 security protection. Other bits read 0.
- R5: The read-side faulting address is captured at 0x070 and the write-side one at 0x080. A pulse captures its address only if it contains a kind whose bit is not already pending. A repeat of a pending kind leaves the address unchanged.
- R6: Writing 0x064 clears every status bit written as 1. If a new fault of the same kind arrives in that cycle, the bit stays set, and for the capture rule it counts as not pending. 0x064 reads 0.
- R7: irq is the OR of the fault status ANDed with the mask at 0x068. The mask holds only the legal status bit positions.
- R8: Any fault pulse puts the unit in ST_DRAIN or ST_HELD in the next cycle. This holds even when a run-code write lands in the same cycle, and the unit stays stopped until a later run-code write.
- R9: A write to 0x00C stores wdata[23:0] as the page frame number, shown on pt_pfn and read back zero-extended. flush_all is high for exactly the cycle after each such write.
- R10: The configuration register at 0x004 is a plain 32-bit read/write register, with reset value 0.
- R11: bus_rdata is registered. In the cycle after a read it shows the register value from before that edge, and 0 in any other cycle. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_req | input | 1 | register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | byte offset |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | registered read data |
| rd_fault | input | 5 | read-side fault pulses, one per kind |
| rd_fault_va | input | 32 | virtual address for rd_fault |
| wr_fault | input | 5 | write-side fault pulses, one per kind |
| wr_fault_va | input | 32 | virtual address for wr_fault |
| xl_start | input | 1 | a translation was accepted |
| xl_done | input | 1 | a translation completed |
| xl_on | output | 1 | translation enabled |
| xl_hold | output | 1 | stop accepting new translations |
| pt_pfn | output | 24 | page table base frame number |
| flush_all | output | 1 | full TLB flush pulse |
| irq | output | 1 | fault interrupt |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a fault pulse and a software write: either a run-code write to 0x000, where the fault must win and keep the unit stopped, or a clear write to 0x064 for the same kind, where the bit must stay set and the new address must be taken. Directed cycles drive both inputs at once and then read back the state and registers. The random phase also fires faults, clears and control writes independently, so they overlap by chance, and a bench model computes the expected values from the requirements.

// File: rtl/mmuc_pkg.sv
package mmuc_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_HELD  = 2'd3
    } xlat_state_e;

    localparam int unsigned CODE_RUN  = 32'h5;
    localparam int unsigned CODE_STOP = 32'h7;
    localparam int unsigned CODE_OFF  = 32'h0;

    localparam int unsigned OFS_CTRL  = 32'h000;
    localparam int unsigned OFS_CFG   = 32'h004;
    localparam int unsigned OFS_STAT  = 32'h008;
    localparam int unsigned OFS_PTB   = 32'h00C;
    localparam int unsigned OFS_FSTAT = 32'h060;
    localparam int unsigned OFS_FCLR  = 32'h064;
    localparam int unsigned OFS_FMASK = 32'h068;
    localparam int unsigned OFS_RVA   = 32'h070;
    localparam int unsigned OFS_WVA   = 32'h080;

endpackage

// File: rtl/mmuc_regbus.sv
module mmuc_regbus
    import mmuc_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] ctrl_view,
    input  logic [DW-1:0] cfg_view,
    input  logic [DW-1:0] stat_view,
    input  logic [DW-1:0] ptb_view,
    input  logic [DW-1:0] fstat_view,
    input  logic [DW-1:0] fmask_view,
    input  logic [DW-1:0] rva_view,
    input  logic [DW-1:0] wva_view,
    output logic          we_ctrl,
    output logic          we_cfg,
    output logic          we_ptb,
    output logic          we_fclr,
    output logic          we_fmask,
    output logic [DW-1:0] bus_rdata
);

    logic          wr_any;
    logic          rd_any;
    logic [DW-1:0] rd_mux;

    assign wr_any = bus_req && bus_we;
    assign rd_any = bus_req && !bus_we;

    always_comb begin
        we_ctrl  = wr_any && (bus_addr == AW'(OFS_CTRL));
        we_cfg   = wr_any && (bus_addr == AW'(OFS_CFG));
        we_ptb   = wr_any && (bus_addr == AW'(OFS_PTB));
        we_fclr  = wr_any && (bus_addr == AW'(OFS_FCLR));
        we_fmask = wr_any && (bus_addr == AW'(OFS_FMASK));
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == AW'(OFS_CTRL))       rd_mux = ctrl_view;
        else if (bus_addr == AW'(OFS_CFG))   rd_mux = cfg_view;
        else if (bus_addr == AW'(OFS_STAT))  rd_mux = stat_view;
        else if (bus_addr == AW'(OFS_PTB))   rd_mux = ptb_view;
        else if (bus_addr == AW'(OFS_FSTAT)) rd_mux = fstat_view;
        else if (bus_addr == AW'(OFS_FMASK)) rd_mux = fmask_view;
        else if (bus_addr == AW'(OFS_RVA))   rd_mux = rva_view;
        else if (bus_addr == AW'(OFS_WVA))   rd_mux = wva_view;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_any) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

endmodule

// File: rtl/mmuc_fsm.sv
module mmuc_fsm
    import mmuc_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [DW-1:0] ctrl_wdata,
    input  logic          fault_any,
    input  logic          xl_start,
    input  logic          xl_done,
    output xlat_state_e   state,
    output logic          xl_on,
    output logic          xl_hold,
    output logic          drained,
    output logic [DW-1:0] ctrl_view
);

    xlat_state_e      state_nxt;
    logic [CNT_W-1:0] inflight;
    logic [CNT_W-1:0] inflight_nxt;
    logic             go_run;
    logic             go_off;
    logic             go_stop;
    logic             bad_code;

    always_comb begin
        go_run   = ctrl_we && !fault_any && (ctrl_wdata == DW'(CODE_RUN));
        go_off   = ctrl_we && !fault_any && (ctrl_wdata == DW'(CODE_OFF));
        go_stop  = fault_any || (ctrl_we && (ctrl_wdata == DW'(CODE_STOP)));
        bad_code = ctrl_we && (ctrl_wdata != DW'(CODE_RUN)) &&
                   (ctrl_wdata != DW'(CODE_OFF)) && (ctrl_wdata != DW'(CODE_STOP));
    end

    assign inflight_nxt = inflight + CNT_W'(xl_start) - CNT_W'(xl_done);

    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF, ST_RUN: begin
                if (go_stop)     state_nxt = ST_DRAIN;
                else if (go_run) state_nxt = ST_RUN;
                else if (go_off) state_nxt = ST_OFF;
            end
            ST_DRAIN: begin
                if (go_run)                  state_nxt = ST_RUN;
                else if (go_off)             state_nxt = ST_OFF;
                else if (inflight_nxt == '0) state_nxt = ST_HELD;
            end
            ST_HELD: begin
                if (go_run)      state_nxt = ST_RUN;
                else if (go_off) state_nxt = ST_OFF;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        xl_on     = 1'b0;
        xl_hold   = 1'b0;
        drained   = 1'b0;
        ctrl_view = DW'(CODE_OFF);
        unique case (state)
            ST_OFF: begin
            end
            ST_RUN: begin
                xl_on     = 1'b1;
                ctrl_view = DW'(CODE_RUN);
            end
            ST_DRAIN: begin
                xl_on     = 1'b1;
                xl_hold   = 1'b1;
                ctrl_view = DW'(CODE_STOP);
            end
            ST_HELD: begin
                xl_on     = 1'b1;
                xl_hold   = 1'b1;
                drained   = 1'b1;
                ctrl_view = DW'(CODE_STOP);
            end
        endcase
    end

    // R3
    held_from_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && $past(state) != ST_HELD) |-> ($past(state) == ST_DRAIN && inflight == '0));

    // R8
    fault_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_any |=> xl_hold);

    // R2
    bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_code && !fault_any && state != ST_DRAIN) |=> (state == $past(state)));

endmodule

// File: rtl/mmuc_fault.sv
module mmuc_fault #(
    parameter int NK   = 5,
    parameter int WOFS = 16,
    parameter int DW   = 32,
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NK-1:0]   rd_fault,
    input  logic [VA_W-1:0] rd_fault_va,
    input  logic [NK-1:0]   wr_fault,
    input  logic [VA_W-1:0] wr_fault_va,
    input  logic            we_fclr,
    input  logic            we_fmask,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   fstat,
    output logic [DW-1:0]   fmask,
    output logic [VA_W-1:0] rva,
    output logic [VA_W-1:0] wva,
    output logic            irq,
    output logic            fault_any
);

    localparam logic [DW-1:0] LANE  = DW'((64'd1 << NK) - 64'd1);
    localparam logic [DW-1:0] LEGAL = LANE | (LANE << WOFS);

    logic [DW-1:0]   clr_vec;
    logic [DW-1:0]   still_set;
    logic [DW-1:0]   set_vec;
    logic [NK-1:0]   pulse   [2];
    logic [VA_W-1:0] pva     [2];
    logic [VA_W-1:0] cap     [2];

    assign pulse[0] = rd_fault;
    assign pulse[1] = wr_fault;
    assign pva[0]   = rd_fault_va;
    assign pva[1]   = wr_fault_va;

    assign clr_vec   = we_fclr ? wdata : '0;
    assign still_set = fstat & ~clr_vec;
    assign set_vec   = (DW'(rd_fault) | (DW'(wr_fault) << WOFS)) & LEGAL;
    assign fault_any = (|rd_fault) || (|wr_fault);

    always_ff @(posedge clk) begin
        if (!rst_n) fstat <= '0;
        else        fstat <= still_set | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        fmask <= LEGAL;
        else if (we_fmask) fmask <= wdata & LEGAL;
    end

    for (genvar d = 0; d < 2; d++) begin : g_dir
        logic [NK-1:0] pend;
        assign pend = still_set[d*WOFS +: NK];
        always_ff @(posedge clk) begin
            if (!rst_n)                   cap[d] <= '0;
            else if (|(pulse[d] & ~pend)) cap[d] <= pva[d];
        end
    end

    assign rva = cap[0];
    assign wva = cap[1];
    assign irq = |(fstat & fmask);

    // R6
    sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(fstat) & ~$past(clr_vec)) & ~fstat) == '0));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fstat == '0) |-> !irq);

endmodule

// File: rtl/mmuc_top.sv
module mmuc_top
    import mmuc_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DW    = 32,
    parameter int VA_W  = 32,
    parameter int PFN_W = 24,
    parameter int NK    = 5,
    parameter int WOFS  = 16,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NK-1:0]    rd_fault,
    input  logic [VA_W-1:0]  rd_fault_va,
    input  logic [NK-1:0]    wr_fault,
    input  logic [VA_W-1:0]  wr_fault_va,
    input  logic             xl_start,
    input  logic             xl_done,
    output logic             xl_on,
    output logic             xl_hold,
    output logic [PFN_W-1:0] pt_pfn,
    output logic             flush_all,
    output logic             irq
);

    xlat_state_e   state;
    logic          we_ctrl, we_cfg, we_ptb, we_fclr, we_fmask;
    logic          drained;
    logic          fault_any;
    logic [DW-1:0] ctrl_view, cfg_q, fstat, fmask;
    logic [VA_W-1:0] rva, wva;

    mmuc_regbus #(.AW(AW), .DW(DW)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .ctrl_view(ctrl_view), .cfg_view(cfg_q),
        .stat_view(DW'(drained)), .ptb_view(DW'(pt_pfn)),
        .fstat_view(fstat), .fmask_view(fmask),
        .rva_view(DW'(rva)), .wva_view(DW'(wva)),
        .we_ctrl(we_ctrl), .we_cfg(we_cfg), .we_ptb(we_ptb),
        .we_fclr(we_fclr), .we_fmask(we_fmask),
        .bus_rdata(bus_rdata)
    );

    mmuc_fsm #(.CNT_W(CNT_W), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(we_ctrl), .ctrl_wdata(bus_wdata),
        .fault_any(fault_any), .xl_start(xl_start), .xl_done(xl_done),
        .state(state), .xl_on(xl_on), .xl_hold(xl_hold),
        .drained(drained), .ctrl_view(ctrl_view)
    );

    mmuc_fault #(.NK(NK), .WOFS(WOFS), .DW(DW), .VA_W(VA_W)) u_flt (
        .clk(clk), .rst_n(rst_n),
        .rd_fault(rd_fault), .rd_fault_va(rd_fault_va),
        .wr_fault(wr_fault), .wr_fault_va(wr_fault_va),
        .we_fclr(we_fclr), .we_fmask(we_fmask), .wdata(bus_wdata),
        .fstat(fstat), .fmask(fmask), .rva(rva), .wva(wva),
        .irq(irq), .fault_any(fault_any)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            pt_pfn    <= '0;
            flush_all <= 1'b0;
        end else begin
            if (we_cfg) cfg_q <= bus_wdata;
            if (we_ptb) pt_pfn <= bus_wdata[PFN_W-1:0];
            flush_all <= we_ptb;
        end
    end

    // R3
    drained_means_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> (xl_hold && state == ST_HELD));

endmodule

// File: tb/sim_mmuc_top.sv
module sim_mmuc_top;
    localparam int TCLK = 10;
    localparam logic [31:0] LEGAL = 32'h001F001F;

    logic clk = 0, rst_n = 0;
    logic bus_req = 0, bus_we = 0;
    logic [11:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [4:0] rd_f = 0, wr_f = 0;
    logic [31:0] rd_va = 0, wr_va = 0;
    logic xl_start = 0, xl_done = 0;
    logic xl_on, xl_hold, flush_all, irq;
    logic [23:0] pt_pfn;

    int nchk = 0, nbad = 0;
    bit finished = 0;

    int ms; int mc;
    logic [31:0] mstat, mmask, mcfg, mrva, mwva;
    logic [23:0] mpt; logic mflush;

    always #(TCLK/2) clk = ~clk;

    mmuc_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rd_fault(rd_f), .rd_fault_va(rd_va), .wr_fault(wr_f), .wr_fault_va(wr_va),
        .xl_start(xl_start), .xl_done(xl_done), .xl_on(xl_on), .xl_hold(xl_hold),
        .pt_pfn(pt_pfn), .flush_all(flush_all), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mread(logic [11:0] a);
        case (a)
            12'h000: return (ms == 0) ? 32'h0 : (ms == 1) ? 32'h5 : 32'h7;
            12'h004: return mcfg;
            12'h008: return {31'b0, ms == 3};
            12'h00C: return {8'b0, mpt};
            12'h060: return mstat;
            12'h068: return mmask;
            12'h070: return mrva;
            12'h080: return mwva;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rtag(logic [11:0] a);
        case (a)
            12'h000: return "R2";
            12'h004: return "R10";
            12'h008: return "R3";
            12'h00C: return "R9";
            12'h060: return "R4";
            12'h068: return "R7";
            12'h070, 12'h080: return "R5";
            default: return "R11";
        endcase
    endfunction

    // one cycle: inputs are set by the caller, model advances, outputs compared
    task automatic step();
        logic [31:0] erd, clr, eff;
        logic [11:0] a;
        int req, cn;
        bit wr;
        a   = bus_addr;
        wr  = bus_req && bus_we;
        erd = (bus_req && !bus_we) ? mread(a) : 32'h0;
        req = 0;
        if (wr && a == 12'h000) begin
            if (bus_wdata == 32'h5) req = 1;
            else if (bus_wdata == 32'h7) req = 2;
            else if (bus_wdata == 32'h0) req = 3;
        end
        if ((rd_f != 0) || (wr_f != 0)) req = 2;
        cn = mc + int'(xl_start) - int'(xl_done);
        @(posedge clk);
        case (ms)
            0, 1: if (req == 1) ms = 1; else if (req == 3) ms = 0; else if (req == 2) ms = 2;
            2: if (req == 1) ms = 1; else if (req == 3) ms = 0; else if (cn == 0) ms = 3;
            default: if (req == 1) ms = 1; else if (req == 3) ms = 0;
        endcase
        mc = cn;
        clr = (wr && a == 12'h064) ? bus_wdata : 32'h0;
        eff = mstat & ~clr;
        if ((rd_f & ~eff[4:0]) != 0) mrva = rd_va;
        if ((wr_f & ~eff[20:16]) != 0) mwva = wr_va;
        mstat = eff | {11'b0, wr_f, 11'b0, rd_f};
        if (wr && a == 12'h068) mmask = bus_wdata & LEGAL;
        if (wr && a == 12'h004) mcfg = bus_wdata;
        if (wr && a == 12'h00C) mpt = bus_wdata[23:0];
        mflush = wr && a == 12'h00C;
        @(negedge clk);
        chk(rtag(a), bus_rdata, erd);
        chk("R2", {31'b0, xl_on}, {31'b0, ms != 0});
        chk("R8", {31'b0, xl_hold}, {31'b0, ms >= 2});
        chk("R7", {31'b0, irq}, {31'b0, (mstat & mmask) != 0});
        chk("R9", {31'b0, flush_all}, {31'b0, mflush});
        chk("R9", {8'b0, pt_pfn}, {8'b0, mpt});
        bus_req = 0; bus_we = 0; rd_f = 0; wr_f = 0; xl_start = 0; xl_done = 0;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; step();
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        bus_req = 1; bus_we = 0; bus_addr = a; step(); v = bus_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        ms = 0; mc = 0; mstat = 0; mmask = LEGAL; mcfg = 0; mrva = 0; mwva = 0; mpt = 0; mflush = 0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd(12'h000, v); chk("R1", v, 0);
        rd(12'h008, v); chk("R1", v, 0);
        rd(12'h060, v); chk("R1", v, 0);
        rd(12'h068, v); chk("R1", v, 32'h001F001F);
        rd(12'h070, v); chk("R1", v, 0);
        chk("R1", {30'b0, irq, xl_on}, 0);
        // R2 control codes
        wr(12'h000, 32'h5); chk("R2", {31'b0, xl_on}, 1);
        wr(12'h000, 32'h3); rd(12'h000, v); chk("R2", v, 32'h5);
        // R3 drain handshake
        xl_start = 1; step(); xl_start = 1; step();
        wr(12'h000, 32'h7); chk("R3", {31'b0, xl_hold}, 1);
        rd(12'h008, v); chk("R3", v, 0);
        xl_done = 1; step();
        rd(12'h008, v); chk("R3", v, 0);
        xl_done = 1; step();
        rd(12'h008, v); chk("R3", v, 1);
        // R4/R8 faults
        wr(12'h000, 32'h5);
        rd_f = 5'b00010; rd_va = 32'hA000_1000; step();
        chk("R8", {31'b0, xl_hold}, 1);
        rd(12'h060, v); chk("R4", v, 32'h2);
        rd(12'h070, v); chk("R5", v, 32'hA000_1000);
        wr_f = 5'b01000; wr_va = 32'hB000_2000; step();
        rd(12'h060, v); chk("R4", v, 32'h0008_0002);
        rd(12'h080, v); chk("R5", v, 32'hB000_2000);
        // R5 pending kind keeps address, new kind replaces
        rd_f = 5'b00010; rd_va = 32'hC000_0000; step();
        rd(12'h070, v); chk("R5", v, 32'hA000_1000);
        rd_f = 5'b10000; rd_va = 32'hD000_0000; step();
        rd(12'h070, v); chk("R5", v, 32'hD000_0000);
        // R6 clear and new fault of same kind together
        bus_req = 1; bus_we = 1; bus_addr = 12'h064; bus_wdata = 32'h0000_0002;
        rd_f = 5'b00010; rd_va = 32'hE000_0000; step();
        rd(12'h060, v); chk("R6", v, 32'h0008_0012);
        rd(12'h070, v); chk("R6", v, 32'hE000_0000);
        wr(12'h064, 32'h0000_0010); rd(12'h060, v); chk("R6", v, 32'h0008_0002);
        // R8 fault wins over run write
        bus_req = 1; bus_we = 1; bus_addr = 12'h000; bus_wdata = 32'h5;
        wr_f = 5'b00001; wr_va = 32'h1234_0000; step();
        chk("R8", {31'b0, xl_hold}, 1);
        rd(12'h000, v); chk("R8", v, 32'h7);
        wr(12'h000, 32'h5); chk("R8", {31'b0, xl_hold}, 0);
        // R7 mask
        wr(12'h068, 32'h0); chk("R7", {31'b0, irq}, 0);
        wr(12'h068, 32'hFFFF_FFFF); chk("R7", {31'b0, irq}, 1);
        rd(12'h068, v); chk("R7", v, LEGAL);
        wr(12'h064, 32'hFFFF_FFFF); chk("R7", {31'b0, irq}, 0);
        // R9 page base
        wr(12'h00C, 32'hABCD_E123); chk("R9", {31'b0, flush_all}, 1);
        step(); chk("R9", {31'b0, flush_all}, 0);
        rd(12'h00C, v); chk("R9", v, 32'h00CD_E123);
        // R10 config, R11 unmapped
        wr(12'h004, 32'h5A5A_0F0F); rd(12'h004, v); chk("R10", v, 32'h5A5A_0F0F);
        wr(12'h044, 32'hFFFF_FFFF); rd(12'h044, v); chk("R11", v, 0);
        rd(12'h064, v); chk("R6", v, 0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 35) begin
                logic [11:0] al [10] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h060,
                                         12'h064, 12'h068, 12'h070, 12'h080, 12'h044};
                bus_req = 1; bus_we = $urandom_range(0, 1);
                bus_addr = al[$urandom_range(0, 9)];
                bus_wdata = $urandom;
                if (bus_addr == 12'h000) begin
                    int c = $urandom_range(0, 3);
                    bus_wdata = (c == 0) ? 32'h0 : (c == 1) ? 32'h5 : (c == 2) ? 32'h7 : 32'h3;
                end
            end
            if ($urandom_range(0, 99) < 6) begin rd_f = 5'($urandom); rd_va = $urandom; end
            if ($urandom_range(0, 99) < 6) begin wr_f = 5'($urandom); wr_va = $urandom; end
            if (ms < 2 && mc < 14 && $urandom_range(0, 1) == 1) xl_start = 1;
            if (mc > 0 && $urandom_range(0, 99) < 40) xl_done = 1;
            step();
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule